// File: doc/BRIEF.md
# Two-Channel Current DAC Control Target on I2C

This block is an I2C target that holds the control bytes for two bipolar current DACs and presents each byte as ready-decoded control lines for the analog circuitry next to it. It runs on a fast system clock. The bus lines SCL and SDA are resynchronised into that clock domain and oversampled. The block drives SDA only through an open-drain enable: when `sda_oe` is high the pad pulls the line low, and otherwise the line is released.

A controller sets a channel by sending the target address with the write bit, a register address, and one data byte. The target keeps the register address as a pointer. A read transaction with no address byte returns the register selected by that pointer. A controller therefore normally writes the register address, issues a repeated START and then reads. Each channel byte is in sign-magnitude form. The top bit chooses sourcing or sinking, the low nibble sets the size of the current, and a size of zero forces the channel inactive whatever the sign is.

Top module: `i2c_cdac_regs`

## Requirements
- R1: The target answers only the 7-bit address `DEV_ADDR` (default 0x48), which is the upper seven bits of the first byte after a START. Bit 0 of that byte selects the direction: 0 writes (byte 0x90) and 1 reads (byte 0x91). The target acknowledges a matching address by driving SDA low for the whole ninth clock.
- R2: A write is START, address byte with bit 0 = 0, register-address byte, data byte, STOP, and the target acknowledges all three bytes. Register `CH0_REG` (default 0xF8) stores the channel 0 byte and `CH1_REG` (default 0xF9) stores the channel 1 byte.
- R3: Each stored byte is decoded onto that channel's outputs. Bit 7 drives `chN_source` (1 = source, 0 = sink) and bits 3:0 drive `chN_mag`. Bits are received MSB first and sampled on the SCL rising edge, and a register changes only in the SCL-low phase that follows the eighth bit of its data byte.
- R4: `chN_active` is 1 when the magnitude nibble is nonzero and 0 when it is 0000, whatever bit 7 holds.
- R5: After reset both registers hold 0x00. Every channel output is then 0, `sda_oe` is 0, and a read of either register returns 0x00.
- R6: If the address byte does not match, the target gives no acknowledge and ignores every following byte until the next START, so no register changes.
- R7: In a read, the target sends the 8-bit register selected by the pointer, MSB first, and changes SDA only after SCL falls. Reserved bits 6:4 read back exactly as they were written.
- R8: The register-address byte sets the pointer. The pointer persists across STOP and START, so a read made with no address byte returns the register that was addressed last.
- R9: A register address other than the two channel registers is still acknowledged. Data written to it is discarded, and a read from it returns 0x00.
- R10: After the eighth bit of a read byte the target releases SDA and keeps it released until the next START, whether the controller acknowledges or not.
- R11: In a write, any byte after the single data byte gets no acknowledge and is discarded.
- R12: A STOP or START in the middle of a byte abandons the byte, and the partial data changes no register.
- R13: The target never changes `sda_oe` while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | Pull SDA low when 1; release the line when 0 |
| ch0_source | output | 1 | Channel 0 direction: 1 source, 0 sink |
| ch0_mag | output | 4 | Channel 0 magnitude step |
| ch0_active | output | 1 | Channel 0 output enabled (nonzero magnitude) |
| ch1_source | output | 1 | Channel 1 direction: 1 source, 0 sink |
| ch1_mag | output | 4 | Channel 1 magnitude step |
| ch1_active | output | 1 | Channel 1 output enabled (nonzero magnitude) |

## Verification
The bench builds the block with its default parameters: device address 0x48 and channel registers at 0xF8 and 0xF9. These values allow a direct comparison of both the write and read address bytes, and of a neighbouring address (0x49) that must be refused. Each SCL phase lasts 20 system clocks, so the synchroniser delay and the edge detection settle well inside every bus phase. The bench samples SDA twice during each high phase, which exposes any drive change made while SCL is high. Unmapped pointer 0x10, an extra fourth write byte, a read acknowledged by the controller, and a STOP after half a data byte cover the refusal and abandonment paths.

// File: rtl/i2c_cdac_regs.sv
module i2c_cdac_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter logic [7:0] CH0_REG  = 8'hF8,
  parameter logic [7:0] CH1_REG  = 8'hF9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       ch0_source,
  output logic [3:0] ch0_mag,
  output logic       ch0_active,
  output logic       ch1_source,
  output logic [3:0] ch1_mag,
  output logic       ch1_active
);

  typedef enum logic [2:0] {
    S_IDLE, S_DEVADR, S_MEMADR, S_WDATA, S_RDATA, S_SKIP
  } st_t;

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_SLOT = 4'd9;

  logic [2:0] scl_sr, sda_sr;
  logic       scl_q, scl_p, sda_q, sda_p;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] shreg, ptr, reg0, reg1, rd_val;
  logic [3:0] bitcnt;
  logic       rx_phase;
  st_t        st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end
  end

  assign scl_q = scl_sr[1];
  assign scl_p = scl_sr[2];
  assign sda_q = sda_sr[1];
  assign sda_p = sda_sr[2];

  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

  assign rd_val   = (ptr == CH0_REG) ? reg0 :
                    (ptr == CH1_REG) ? reg1 : 8'h00;
  assign rx_phase = (st == S_DEVADR) || (st == S_MEMADR) || (st == S_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      reg0   <= '0;
      reg1   <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= S_DEVADR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (bitcnt == ACK_SLOT) begin
      if (scl_fall) begin
        bitcnt <= '0;
        if (st == S_RDATA) begin
          shreg  <= rd_val;
          sda_oe <= ~rd_val[7];
        end else begin
          sda_oe <= 1'b0;
        end
      end
    end else if (rx_phase) begin
      if (scl_rise && bitcnt < LAST_BIT) begin
        shreg  <= {shreg[6:0], sda_q};
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall && bitcnt == LAST_BIT) begin
        bitcnt <= ACK_SLOT;
        case (st)
          S_DEVADR: begin
            if (shreg[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              st     <= shreg[0] ? S_RDATA : S_MEMADR;
            end else begin
              st <= S_SKIP;
            end
          end
          S_MEMADR: begin
            ptr    <= shreg;
            sda_oe <= 1'b1;
            st     <= S_WDATA;
          end
          default: begin
            if (ptr == CH0_REG) reg0 <= shreg;
            else if (ptr == CH1_REG) reg1 <= shreg;
            sda_oe <= 1'b1;
            st     <= S_SKIP;
          end
        endcase
      end
    end else if (st == S_RDATA) begin
      if (scl_rise) begin
        if (bitcnt == LAST_BIT) st <= S_SKIP;
        else bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall && bitcnt != 4'd0) begin
        if (bitcnt == LAST_BIT) begin
          sda_oe <= 1'b0;
        end else begin
          shreg  <= {shreg[6:0], 1'b0};
          sda_oe <= ~shreg[6];
        end
      end
    end
  end

  assign ch0_source = reg0[7];
  assign ch0_mag    = reg0[3:0];
  assign ch0_active = |reg0[3:0];
  assign ch1_source = reg1[7];
  assign ch1_mag    = reg1[3:0];
  assign ch1_active = |reg1[3:0];

endmodule

// File: rtl/i2c_cdac_regs_chk.sv
module i2c_cdac_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_hi,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       in_skip,
  input logic       in_idle,
  input logic       ack_slot,
  input logic       sda_oe,
  input logic       ch0_source,
  input logic [3:0] ch0_mag,
  input logic       ch0_active,
  input logic       ch1_source,
  input logic [3:0] ch1_mag,
  input logic       ch1_active
);

  p_reset_clear_r5: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !ch0_active && !ch1_active && !ch0_source &&
                !ch1_source && ch0_mag == 4'd0 && ch1_mag == 4'd0));

  p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  p_sda_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && !start_det && !stop_det) |=> $stable(sda_oe));

  p_regs_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable({ch0_source, ch0_mag, ch1_source, ch1_mag}));

  p_skip_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_skip && !ack_slot) |-> !sda_oe);

endmodule

bind i2c_cdac_regs i2c_cdac_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_hi    (scl_q),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .in_skip   (st == S_SKIP),
  .in_idle   (st == S_IDLE),
  .ack_slot  (bitcnt == ACK_SLOT),
  .sda_oe    (sda_oe),
  .ch0_source(ch0_source),
  .ch0_mag   (ch0_mag),
  .ch0_active(ch0_active),
  .ch1_source(ch1_source),
  .ch1_mag   (ch1_mag),
  .ch1_active(ch1_active)
);

// File: tb/i2c_cdac_regs_test.sv
`timescale 1ns/1ps
module i2c_cdac_regs_test;

  localparam int Q = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic ctl_sda = 1'b1;
  logic sda_oe;
  logic ch0_source, ch0_active, ch1_source, ch1_active;
  logic [3:0] ch0_mag, ch1_mag;
  wire  sda_bus = ctl_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit hi_glitch = 1'b0;

  always #2.5 clk = ~clk;

  i2c_cdac_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .ch0_source(ch0_source), .ch0_mag(ch0_mag), .ch0_active(ch0_active),
    .ch1_source(ch1_source), .ch1_mag(ch1_mag), .ch1_active(ch1_active)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_ch0(input string tag, input logic s, input logic [3:0] m, input logic a);
    check(tag, {2'b00, ch0_source, ch0_active, ch0_mag}, {2'b00, s, a, m});
  endtask

  task automatic check_ch1(input string tag, input logic s, input logic [3:0] m, input logic a);
    check(tag, {2'b00, ch1_source, ch1_active, ch1_mag}, {2'b00, s, a, m});
  endtask

  task automatic bus_start();
    ctl_sda = 1'b1; #Q;
    scl = 1'b1; #Q;
    ctl_sda = 1'b0; #Q;
    scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    ctl_sda = 1'b0; #Q;
    scl = 1'b1; #Q;
    ctl_sda = 1'b1; #Q;
  endtask

  task automatic bit_xfer(input logic v, output logic s);
    logic early;
    ctl_sda = v; #Q;
    scl = 1'b1; #(Q/2);
    early = sda_bus; #(Q/2);
    s = sda_bus;
    if (early !== s) hi_glitch = 1'b1;
    scl = 1'b0; #Q;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, nack);
  endtask

  task automatic get_byte(input logic ctl_nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(ctl_nack, s);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data, output logic [2:0] n);
    bus_start();
    put_byte(8'h90, n[2]);
    put_byte(addr, n[1]);
    put_byte(data, n[0]);
    bus_stop();
  endtask

  task automatic rd_at(input logic [7:0] addr, output logic [7:0] d);
    logic n;
    bus_start();
    put_byte(8'h90, n);
    put_byte(addr, n);
    bus_start();
    put_byte(8'h91, n);
    get_byte(1'b1, d);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R5 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    check_ch0("R5 ch0 after reset", 1'b0, 4'h0, 1'b0);
    check_ch1("R5 ch1 after reset", 1'b0, 4'h0, 1'b0);
    rd_at(8'hF8, d); check("R5 read F8 after reset", d, 8'h00);
    rd_at(8'hF9, d); check("R5 read F9 after reset", d, 8'h00);
  endtask

  task automatic t_write_channels();
    logic [2:0] n;
    wr(8'hF8, 8'h8A, n);
    check("R1 R2 acks write F8", {5'd0, n}, 8'h00);
    check_ch0("R2 R3 R4 ch0 source A", 1'b1, 4'hA, 1'b1);
    check_ch1("R2 ch1 untouched", 1'b0, 4'h0, 1'b0);
    wr(8'hF9, 8'h05, n);
    check("R2 acks write F9", {5'd0, n}, 8'h00);
    check_ch1("R3 R4 ch1 sink 5", 1'b0, 4'h5, 1'b1);
    check_ch0("R2 ch0 kept", 1'b1, 4'hA, 1'b1);
  endtask

  task automatic t_zero_code();
    logic [2:0] n;
    wr(8'hF8, 8'h80, n);
    check_ch0("R4 source zero inactive", 1'b1, 4'h0, 1'b0);
  endtask

  task automatic t_readback();
    logic [2:0] n;
    logic [7:0] d;
    logic na;
    wr(8'hF9, 8'h75, n);
    check_ch1("R3 reserved bits ignored by decode", 1'b0, 4'h5, 1'b1);
    rd_at(8'hF9, d); check("R7 read F9 with reserved", d, 8'h75);
    bus_start();
    put_byte(8'h91, na);
    check("R1 read address ack", {7'd0, na}, 8'h00);
    get_byte(1'b1, d);
    bus_stop();
    check("R8 read at kept pointer", d, 8'h75);
    rd_at(8'hF8, d); check("R7 read F8", d, 8'h80);
  endtask

  task automatic t_wrong_addr();
    logic a, b, c;
    bus_start();
    put_byte(8'hA0, a);
    put_byte(8'hF8, b);
    put_byte(8'h0F, c);
    bus_stop();
    check("R6 foreign address nack", {5'd0, a, b, c}, 8'h07);
    check_ch0("R6 ch0 unchanged", 1'b1, 4'h0, 1'b0);
    bus_start();
    put_byte(8'h92, a);
    bus_stop();
    check("R1 neighbour address nack", {7'd0, a}, 8'h01);
  endtask

  task automatic t_unmapped();
    logic [2:0] n;
    logic [7:0] d;
    wr(8'h10, 8'hFF, n);
    check("R9 unmapped acked", {5'd0, n}, 8'h00);
    check_ch0("R9 ch0 unchanged", 1'b1, 4'h0, 1'b0);
    check_ch1("R9 ch1 unchanged", 1'b0, 4'h5, 1'b1);
    rd_at(8'h10, d); check("R9 unmapped reads zero", d, 8'h00);
  endtask

  task automatic t_extra_byte();
    logic [3:0] n;
    bus_start();
    put_byte(8'h90, n[3]);
    put_byte(8'hF9, n[2]);
    put_byte(8'h03, n[1]);
    put_byte(8'h0C, n[0]);
    bus_stop();
    check("R11 fourth byte nack", {4'd0, n}, 8'h01);
    check_ch1("R11 ch1 keeps first data", 1'b0, 4'h3, 1'b1);
  endtask

  task automatic t_read_acked();
    logic [7:0] d0, d1;
    logic n;
    bus_start();
    put_byte(8'h90, n);
    put_byte(8'hF9, n);
    bus_start();
    put_byte(8'h91, n);
    get_byte(1'b0, d0);
    get_byte(1'b1, d1);
    bus_stop();
    check("R7 read F9", d0, 8'h03);
    check("R10 line released after read", d1, 8'hFF);
  endtask

  task automatic t_stop_abort();
    logic n, s;
    logic [7:0] d;
    bus_start();
    put_byte(8'h90, n);
    put_byte(8'hF8, n);
    for (int i = 0; i < 4; i++) bit_xfer(1'b1, s);
    bus_stop();
    check_ch0("R12 partial byte dropped", 1'b1, 4'h0, 1'b0);
    bus_start();
    put_byte(8'h91, n);
    get_byte(1'b1, d);
    bus_stop();
    check("R12 R8 pointer from aborted write", d, 8'h80);
  endtask

  task automatic t_sink_write();
    logic [2:0] n;
    wr(8'hF8, 8'h0C, n);
    check_ch0("R3 ch0 sink C", 1'b0, 4'hC, 1'b1);
    check("R13 no drive change with SCL high", {7'd0, hi_glitch}, 8'h00);
  endtask

  initial begin
    #(Q + 2);
    rst_n = 1'b1;
    #(Q - 2);
    t_reset();
    t_write_channels();
    t_zero_code();
    t_readback();
    t_wrong_addr();
    t_unmapped();
    t_extra_byte();
    t_read_acked();
    t_stop_abort();
    t_sink_write();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule